// File: doc/BRIEF.md
# Clock-Configuration Block-Transfer I2C Slave

This block is an I2C slave for standard-mode buses (up to 100 kbit/s) that holds six 8-bit configuration bytes for a clock generator. The bus lines are oversampled by the system clock through two-flop synchronizers, and start and stop conditions are found as SDA edges while SCL is high. The slave drives SDA only by pulling it low through an output enable. It does not stretch the clock, does not arbitrate between masters, and has no random register addressing.

Only block transfers exist. A write to address byte 0xD2 carries a command byte and a count byte, which are acknowledged and thrown away. The data bytes that follow always land in register 0, then 1, and so on. The master may stop after any whole byte. A read from address byte 0xD3 returns a byte count of 6 and then registers 0 to 5. In registers 1 to 5 a bit set to 1 enables a clock output. Reserved bits always read 1. Four strap bits, taken from the board at power-up, appear read-only in registers 3 and 4.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The slave acknowledges the address bytes 0xD2 (write) and 0xD3 (read). Any other address byte gets no acknowledge, SDA stays released for the rest of that transfer, and no register changes.
- R2: On a write, the slave acknowledges the two bytes after the address and discards their values. Each data byte after them is acknowledged, and data byte i loads register i, starting at register 0. Register k appears on cfg_o[8k+7:8k].
- R3: A stop after any complete byte ends the write. Registers already loaded keep their new values and the other registers are unchanged.
- R4: Data bytes past register 5 are acknowledged and discarded.
- R5: On a read, the slave sends the value 6 first, then registers 0 to 5, most significant bit first. Any byte the master requests after register 5 reads 0xFF.
- R6: When the master does not acknowledge a read byte, the slave releases SDA and sends nothing more until the next start.
- R7: After reset, register 0 is 0x00 and every writable bit of registers 1 to 5 is 1.
- R8: Writable bit masks: register 0 0xFF, register 1 0x0F, register 2 0x7F, register 3 0x00, register 4 0x0F, register 5 0x3F. Reserved bits always read 1 and ignore writes. The reserved masks are: register 1 0xF0, register 2 0x80, register 3 0xF8, register 4 0x70, register 5 0xC0.
- R9: Strap bits are read-only and follow strap_i. Register 3 bits [2:0] show strap_i[2:0] and register 4 bit 7 shows strap_i[3]. Writes to these bits have no effect.
- R10: The slave changes its SDA output enable only while SCL is low.
- R11: A repeated start inside a transfer starts a new address phase. Bytes written before it keep their effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 4 | Strap levels latched on the board, shown read-only |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cfg_o | output | 48 | Readback of the six registers, register k in bits [8k+7:8k] |

## Verification
The hardest case to reach is a write cut short at each possible byte boundary, because the slave's internal byte position is not visible at the ports. The bench sweeps the number of data bytes from zero to six. Each length uses a new data pattern, so the bench can tell a register that was loaded from one that only kept its old value. Every write is read back as a block and checked against a model of the masks. A repeated start, a read that runs past register 5, and a sweep over all sixteen strap values reach the remaining corners.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    localparam int NUM_REGS    = 6;
    localparam int BYTE_W      = 8;
    localparam int IDX_W       = $clog2(NUM_REGS);
    localparam int POS_W       = $clog2(NUM_REGS + 3);
    localparam int STRAP_W     = 4;
    localparam int HDR_BYTES   = 2;

    localparam logic [BYTE_W-1:0] ADDR_WR = 8'hD2;
    localparam logic [BYTE_W-1:0] ADDR_RD = 8'hD3;
    localparam logic [POS_W-1:0]  POS_MAX = POS_W'(NUM_REGS + HDR_BYTES);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WRX,
        ST_TX,
        ST_MACK
    } eng_state_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } reg_wr_t;

    function automatic logic [BYTE_W-1:0] wr_mask(int k);
        case (k)
            0:       return 8'hFF;
            1:       return 8'h0F;
            2:       return 8'h7F;
            4:       return 8'h0F;
            5:       return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] rsv_mask(int k);
        case (k)
            1:       return 8'hF0;
            2:       return 8'h80;
            3:       return 8'hF8;
            4:       return 8'h70;
            5:       return 8'hC0;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] strap_bits(int k, logic [STRAP_W-1:0] s);
        case (k)
            3:       return {5'b0, s[2:0]};
            4:       return {s[3], 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] reg_default(int k);
        return (k == 0) ? 8'h00 : wr_mask(k);
    endfunction

endpackage

// File: rtl/clkcfg_bus_sync.sv
module clkcfg_bus_sync
    import clkcfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;
    logic              sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_s;
            sda_q  <= sda_s;
        end
    end

    assign scl_s = scl_sh[STAGES-1];
    assign sda_s = sda_sh[STAGES-1];

    always_comb begin
        evt.scl_lvl  = scl_s;
        evt.sda_lvl  = sda_s;
        evt.scl_rise = scl_s & ~scl_q;
        evt.scl_fall = ~scl_s & scl_q;
        evt.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

    AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.scl_rise, evt.scl_fall, evt.start, evt.stop})) else $error("bus events overlap"); // R11

endmodule

// File: rtl/clkcfg_bus_engine.sv
module clkcfg_bus_engine
    import clkcfg_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  bus_evt_t                        evt,
    input  logic [NUM_REGS-1:0][BYTE_W-1:0] rb,
    output reg_wr_t                         wr,
    output logic                            sda_oe
);

    eng_state_e        st;
    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] tx;
    logic [3:0]        cnt;
    logic [POS_W-1:0]  pos;
    logic              rd_mode;
    logic              nack;
    logic [BYTE_W-1:0] tx_next;
    logic [POS_W-1:0]  pos_inc;
    logic              pos_is_data;

    always_comb begin
        if (pos == '0)
            tx_next = BYTE_W'(NUM_REGS);
        else if (pos <= POS_W'(NUM_REGS))
            tx_next = rb[IDX_W'(pos - POS_W'(1))];
        else
            tx_next = 8'hFF;
    end

    assign pos_inc     = (pos == POS_MAX) ? pos : pos + POS_W'(1);
    assign pos_is_data = (pos >= POS_W'(HDR_BYTES)) && (pos < POS_W'(HDR_BYTES + NUM_REGS));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sr      <= '0;
            tx      <= '0;
            cnt     <= '0;
            pos     <= '0;
            rd_mode <= 1'b0;
            nack    <= 1'b1;
            sda_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            sr  <= {sr[BYTE_W-2:0], evt.sda_lvl};
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall && cnt == 4'd8) begin
                            pos <= '0;
                            if (sr == ADDR_WR) begin
                                rd_mode <= 1'b0;
                                st      <= ST_ACK;
                                sda_oe  <= 1'b1;
                            end else if (sr == ADDR_RD) begin
                                rd_mode <= 1'b1;
                                st      <= ST_ACK;
                                sda_oe  <= 1'b1;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            if (rd_mode) begin
                                tx     <= tx_next;
                                sda_oe <= ~tx_next[BYTE_W-1];
                                pos    <= pos_inc;
                                st     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_WRX;
                            end
                        end
                    end
                    ST_WRX: begin
                        if (evt.scl_rise) begin
                            sr  <= {sr[BYTE_W-2:0], evt.sda_lvl};
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall && cnt == 4'd8) begin
                            wr.en   <= pos_is_data;
                            wr.idx  <= IDX_W'(pos - POS_W'(HDR_BYTES));
                            wr.data <= sr;
                            pos     <= pos_inc;
                            st      <= ST_ACK;
                            sda_oe  <= 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (evt.scl_fall) begin
                            if (cnt == 4'd8) begin
                                st     <= ST_MACK;
                                sda_oe <= 1'b0;
                            end else begin
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~tx[BYTE_W-2];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (evt.scl_rise) begin
                            nack <= evt.sda_lvl;
                        end else if (evt.scl_fall) begin
                            if (nack) begin
                                st <= ST_IDLE;
                            end else begin
                                cnt    <= '0;
                                tx     <= tx_next;
                                sda_oe <= ~tx_next[BYTE_W-1];
                                pos    <= pos_inc;
                                st     <= ST_TX;
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (evt.scl_lvl && $past(evt.scl_lvl) && !$past(evt.start) && !$past(evt.stop))
        |-> $stable(sda_oe)) else $error("SDA enable moved while SCL high"); // R10

    AST_WR_FROM_DATA: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> ($past(st) == ST_WRX && st == ST_ACK)) else $error("write pulse outside data byte"); // R2

    AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MACK && evt.scl_fall && nack) |=> (!sda_oe && st == ST_IDLE)) else $error("no release after NACK"); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && $past(st) == ST_IDLE) |-> !sda_oe) else $error("driving SDA while idle"); // R1

endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
    import clkcfg_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  reg_wr_t                         wr,
    input  logic [STRAP_W-1:0]              strap_i,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] rb
);

    logic [BYTE_W-1:0] wq [NUM_REGS];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                wq[k] <= reg_default(k);
            else if (wr.en && wr.idx == IDX_W'(k))
                wq[k] <= wr.data & wr_mask(k);
        end

        assign rb[k] = (wq[k] & wr_mask(k)) | rsv_mask(k) | strap_bits(k, strap_i);

        AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
            !($past(wr.en) && $past(wr.idx) == IDX_W'(k)) |-> $stable(wq[k])) else $error("register moved without write"); // R3
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (int'(wr.idx) < NUM_REGS)) else $error("write index past last register"); // R4

endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         scl_i,
    input  logic                         sda_i,
    input  logic [STRAP_W-1:0]           strap_i,
    output logic                         sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0]   cfg_o
);

    bus_evt_t                        evt;
    reg_wr_t                         wr;
    logic [NUM_REGS-1:0][BYTE_W-1:0] rb;

    clkcfg_bus_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    clkcfg_bus_engine engine_i (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .rb     (rb),
        .wr     (wr),
        .sda_oe (sda_oe)
    );

    clkcfg_regbank regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .strap_i (strap_i),
        .rb      (rb)
    );

    assign cfg_o = rb;

endmodule

// File: tb/clkcfg_i2c_slave_tb_top.sv
module clkcfg_i2c_slave_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [3:0]  strap = 4'b1010;
    logic        sda_oe;
    logic [47:0] cfg;
    logic        sda_line;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m_w   [6];
    logic [7:0] wbuf  [10];
    logic [7:0] rdbuf [8];

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkcfg_i2c_slave dut_i (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .strap_i (strap),
        .sda_oe  (sda_oe),
        .cfg_o   (cfg)
    );

    function automatic logic [7:0] wmask(int k);
        logic [7:0] t [6] = '{8'hFF, 8'h0F, 8'h7F, 8'h00, 8'h0F, 8'h3F};
        return t[k];
    endfunction

    function automatic logic [7:0] rmask(int k);
        logic [7:0] t [6] = '{8'h00, 8'hF0, 8'h80, 8'hF8, 8'h70, 8'hC0};
        return t[k];
    endfunction

    function automatic logic [7:0] exp_b(int k);
        logic [7:0] s;
        s = (k == 3) ? {5'b0, strap[2:0]} : (k == 4) ? {strap[3], 7'b0} : 8'h00;
        return (m_w[k] & wmask(k)) | rmask(k) | s;
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        b = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~mack);
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        for (int k = 0; k < 6; k++)
            chk(cfg[8*k +: 8] == exp_b(k), tag, cfg[8*k +: 8], exp_b(k));
    endtask

    // n data bytes from wbuf after address, command and count
    task automatic do_write(input int n);
        logic ack;
        bus_start();
        send_byte(8'hD2, ack);
        chk(ack, "R1 write address ack", {7'b0, ack}, 8'h01);
        send_byte(8'h03, ack);
        chk(ack, "R2 command ack", {7'b0, ack}, 8'h01);
        send_byte(8'h02, ack);
        chk(ack, "R2 count ack", {7'b0, ack}, 8'h01);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            chk(ack, (i < 6) ? "R2 data ack" : "R4 extra byte ack", {7'b0, ack}, 8'h01);
            if (i < 6) m_w[i] = wbuf[i];
        end
        bus_stop();
    endtask

    task automatic do_read(input int n);
        logic ack;
        bus_start();
        send_byte(8'hD3, ack);
        chk(ack, "R1 read address ack", {7'b0, ack}, 8'h01);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rdbuf[i]);
        wq();
        chk(sda_line == 1'b1, "R6 released after NACK", {7'b0, sda_line}, 8'h01);
        bus_stop();
    endtask

    task automatic check_read(input string tag);
        do_read(7);
        chk(rdbuf[0] == 8'd6, "R5 byte count", rdbuf[0], 8'd6);
        for (int k = 0; k < 6; k++)
            chk(rdbuf[k+1] == exp_b(k), tag, rdbuf[k+1], exp_b(k));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic ack;
        m_w = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R7 reset state
        chk(sda_oe == 1'b0, "R7 idle after reset", {7'b0, sda_oe}, 8'h00);
        check_all("R7 reset value");
        check_read("R7 reset readback");

        // R2 R4 R8 full write plus two extra bytes
        for (int i = 0; i < 8; i++) wbuf[i] = 8'hFF - 8'(i * 17);
        do_write(8);
        check_all("R8 masked after full write");
        check_read("R4 readback after overlong write");

        // R3 early stop after each byte position
        for (int n = 0; n <= 6; n++) begin
            for (int i = 0; i < 6; i++) wbuf[i] = 8'(8'h5A ^ (n * 8'h13) ^ (i * 8'h29));
            do_write(n);
            check_all("R3 partial write outputs");
            check_read("R3 partial write readback");
        end

        // R1 foreign addresses ignored
        for (int a = 0; a < 4; a++) begin
            logic [7:0] addr;
            addr = (a == 0) ? 8'hA0 : (a == 1) ? 8'hD0 : (a == 2) ? 8'hD6 : 8'h52;
            bus_start();
            send_byte(addr, ack);
            chk(!ack, "R1 foreign address no ack", {7'b0, ack}, 8'h00);
            send_byte(8'h00, ack);
            chk(!ack, "R1 no ack after foreign address", {7'b0, ack}, 8'h00);
            bus_stop();
            check_all("R1 registers unchanged");
        end

        // R9 strap sweep with write attempt
        for (int i = 0; i < 6; i++) wbuf[i] = 8'h00;
        do_write(6);
        for (int s = 0; s < 16; s++) begin
            strap = 4'(s);
            repeat (2) @(negedge clk);
            chk(cfg[26:24] == strap[2:0], "R9 strap low bits", {5'b0, cfg[26:24]}, {5'b0, strap[2:0]});
            chk(cfg[39] == strap[3], "R9 strap high bit", {7'b0, cfg[39]}, {7'b0, strap[3]});
        end
        check_read("R9 strap readback after zero write");

        // R11 repeated start between write and read
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, ack);
        send_byte(8'h00, ack);
        send_byte(8'hC3, ack);
        chk(ack, "R11 data ack before restart", {7'b0, ack}, 8'h01);
        m_w[0] = 8'hC3;
        bus_start();
        send_byte(8'hD3, ack);
        chk(ack, "R11 address after restart", {7'b0, ack}, 8'h01);
        recv_byte(1'b1, rdbuf[0]);
        recv_byte(1'b0, rdbuf[1]);
        bus_stop();
        chk(rdbuf[0] == 8'd6, "R11 count after restart", rdbuf[0], 8'd6);
        chk(rdbuf[1] == 8'hC3, "R11 register 0 after restart", rdbuf[1], 8'hC3);

        // R5 read past last register
        do_read(8);
        chk(rdbuf[7] == 8'hFF, "R5 byte past last register", rdbuf[7], 8'hFF);
        chk(rdbuf[6] == exp_b(5), "R5 last register", rdbuf[6], exp_b(5));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule